// File: doc/BRIEF.md
# Latency-Insensitive Two-Way Multiplexer with Stale-Token Dropping

This block picks one of two data token streams for each model cycle, in a network where every wire is carried as a queue of tokens. A select queue says which input feeds the output for that cycle. The block emits the output token once the select token and the token on the chosen input are both present. It does not wait for the other input, whose value is a don't-care for that cycle.

Every input stream still carries exactly one token per model cycle. The block therefore keeps, for each data input, a count of tokens it has skipped and still owes. When those tokens arrive they are consumed and thrown away. This keeps each stream aligned to model cycles and guarantees that every token entering the block is eventually consumed.

All four edges are valid/ready queue heads. An input `*_valid` means the queue is not empty, and `*_ready` dequeues its head in that cycle. `out_valid` enqueues into the output queue, and `out_ready` means that queue is not full.

Top module: `li_drop_mux`

## Requirements
- R1: `out_valid` is high exactly when all of these hold: `sel_valid` is high, the chosen input is valid, the chosen input owes no drops, and the unchosen input's drop count is below `DROP_MAX`. The select value 0 chooses input A and 1 chooses input B. `out_data` then equals the chosen input's data.
- R2: The output for a model cycle never waits on the unchosen data input; its valid has no effect on `out_valid`.
- R3: When `out_valid` and `out_ready` are both high, `sel_ready` and the chosen input's ready are high in that cycle. `sel_ready` is high in no other cycle.
- R4: A transfer on the output adds one to the unchosen input's drop count. The next token that arrives on that input is then consumed without reaching the output.
- R5: While an input's drop count is non-zero, its ready is high. Each token it accepts in that state is discarded and lowers the count by one. With a zero count and no transfer, its ready is low.
- R6: An input whose drop count is non-zero cannot feed the output. `out_valid` stays low for a select token that chooses it until its count is zero.
- R7: When the unchosen input's drop count equals `DROP_MAX`, the select token is not accepted and `out_valid` stays low, until a drop on that input frees space.
- R8: `out_valid` does not depend on `out_ready`. While `out_ready` is low, no select or chosen data token is consumed.
- R9: The n-th output token is the one chosen by the n-th select token.
- R10: After reset both drop counts are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_valid | input | 1 | Select queue not empty |
| sel_data | input | 1 | Select token, 0 = input A, 1 = input B |
| sel_ready | output | 1 | Dequeue select token |
| a_valid | input | 1 | Input A queue not empty |
| a_data | input | DATA_W | Input A head token |
| a_ready | output | 1 | Dequeue input A (used or discarded) |
| b_valid | input | 1 | Input B queue not empty |
| b_data | input | DATA_W | Input B head token |
| b_ready | output | 1 | Dequeue input B (used or discarded) |
| out_valid | output | 1 | Enqueue into output queue |
| out_data | output | DATA_W | Output token |
| out_ready | input | 1 | Output queue not full |

## Verification
The bench builds the block with `DATA_W = 8` and `DROP_MAX = 2`. A limit this small lets a few consecutive picks of one input drive the other input's count to saturation. This makes the select stall, release on a single drop, and the case where a token is used and a token is dropped in the same cycle easy to reach. An 8-bit width lets each token carry a distinct value, so the order of select tokens against output tokens can be read directly from the output data.

// File: rtl/li_drop_mux_pkg.sv
// Package: shared types for the latency-insensitive drop multiplexer.
// Assumes two data inputs, indexed by the select token value.
package li_drop_mux_pkg;

    // Which data input feeds the output for a model cycle.
    typedef enum logic {
        PICK_A = 1'b0,
        PICK_B = 1'b1
    } pick_e;

    // Number of data inputs handled by the multiplexer.
    localparam int unsigned NUM_INPUTS = 2;

endpackage

// File: rtl/li_drop_counter.sv
// Module: li_drop_counter
// Counts tokens still owed (to be discarded) on one data input.
// Assumes the caller never raises 'owe' while the count is at LIMIT
// without a simultaneous 'paid'; the count saturates as a safety net.
module li_drop_counter #(
    parameter int unsigned LIMIT = 3,
    localparam int unsigned CW   = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic owe,      // one more token must be dropped later
    input  logic paid,     // one owed token was dropped this cycle
    output logic pending,  // count is non-zero
    output logic at_limit  // count equals LIMIT
);

    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] count_q;

    // Track the owed-token count with saturation at both ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (owe && !paid) begin
            if (count_q != LIM) count_q <= count_q + 1'b1;
        end else if (paid && !owe) begin
            if (count_q != '0) count_q <= count_q - 1'b1;
        end
    end

    // Expose the two conditions the steering logic needs.
    always_comb begin
        pending  = (count_q != '0);
        at_limit = (count_q == LIM);
    end

endmodule

// File: rtl/li_drop_steer.sv
// Module: li_drop_steer
// Combinational steering: decides output transfer, dequeues and drops.
// Assumes input valids are queue-not-empty and out_ready is queue-not-full.
module li_drop_steer
    import li_drop_mux_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              sel_valid,
    input  pick_e             pick,
    input  logic [1:0]        in_valid,
    input  logic [DATA_W-1:0] in_data [2],
    input  logic [1:0]        pending,
    input  logic [1:0]        at_limit,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              sel_ready,
    output logic [1:0]        in_ready,
    output logic [1:0]        owe,
    output logic [1:0]        paid
);

    logic chosen_idx;
    logic other_idx;
    logic fire;

    // Form the output handshake from the select and chosen input only.
    always_comb begin
        chosen_idx = pick;
        other_idx  = ~pick;
        out_valid  = sel_valid && in_valid[chosen_idx] &&
                     !pending[chosen_idx] && !at_limit[other_idx];
        out_data   = in_data[chosen_idx];
        fire       = out_valid && out_ready;
        sel_ready  = fire;
    end

    // Per input: consume when used, discard when owed, record new debt.
    for (genvar g = 0; g < 2; g++) begin : g_lane
        always_comb begin
            paid[g]     = pending[g] && in_valid[g];
            owe[g]      = fire && (other_idx == 1'(g));
            in_ready[g] = pending[g] || (fire && (chosen_idx == 1'(g)));
        end
    end

endmodule

// File: rtl/li_drop_mux.sv
// Module: li_drop_mux (top)
// Two-way latency-insensitive multiplexer that does not wait for the
// don't-care input and discards the owed tokens later.
// Assumes every port pair is a queue head (valid = not empty, ready = deq)
// or a queue tail (valid = enq, ready = not full).
module li_drop_mux
    import li_drop_mux_pkg::*;
#(
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned DROP_MAX = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_valid,
    input  logic              sel_data,
    output logic              sel_ready,
    input  logic              a_valid,
    input  logic [DATA_W-1:0] a_data,
    output logic              a_ready,
    input  logic              b_valid,
    input  logic [DATA_W-1:0] b_data,
    output logic              b_ready,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    input  logic              out_ready
);

    logic [1:0]        in_valid;
    logic [DATA_W-1:0] in_data [2];
    logic [1:0]        in_ready;
    logic [1:0]        pending;
    logic [1:0]        at_limit;
    logic [1:0]        owe;
    logic [1:0]        paid;
    pick_e             pick;

    // Gather the two data inputs into indexed form.
    always_comb begin
        in_valid   = {b_valid, a_valid};
        in_data[0] = a_data;
        in_data[1] = b_data;
        pick       = pick_e'(sel_data);
        a_ready    = in_ready[0];
        b_ready    = in_ready[1];
    end

    // One owed-token counter per data input.
    for (genvar g = 0; g < NUM_INPUTS; g++) begin : g_cnt
        li_drop_counter #(
            .LIMIT (DROP_MAX)
        ) i_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .owe      (owe[g]),
            .paid     (paid[g]),
            .pending  (pending[g]),
            .at_limit (at_limit[g])
        );
    end

    li_drop_steer #(
        .DATA_W (DATA_W)
    ) i_steer (
        .sel_valid (sel_valid),
        .pick      (pick),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .pending   (pending),
        .at_limit  (at_limit),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .sel_ready (sel_ready),
        .in_ready  (in_ready),
        .owe       (owe),
        .paid      (paid)
    );

endmodule

// File: rtl/li_drop_mux_checker.sv
// Module: li_drop_mux_checker
// Port-level properties of li_drop_mux; attached with bind below.
module li_drop_mux_checker #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sel_valid,
    input logic              sel_data,
    input logic              sel_ready,
    input logic              a_valid,
    input logic [DATA_W-1:0] a_data,
    input logic              a_ready,
    input logic              b_valid,
    input logic [DATA_W-1:0] b_data,
    input logic              b_ready,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data,
    input logic              out_ready
);

    // R1: an output token needs a select token and a valid chosen input.
    a_r1_needs_sel: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> sel_valid && (sel_data ? b_valid : a_valid));

    // R1: the output carries the chosen input's token.
    a_r1_data: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_data == (sel_data ? b_data : a_data));

    // R3: the select token is consumed only on an output transfer.
    a_r3_sel_only_on_fire: assert property (@(posedge clk) disable iff (!rst_n)
        sel_ready |-> out_valid && out_ready);

    // R3: a transfer also dequeues the chosen input.
    a_r3_chosen_dequeued: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready |-> (sel_data ? b_ready : a_ready));

    // R4: after picking A the B input owes a drop, so B is ready next cycle.
    a_r4_owe_b: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && !sel_data |=> b_ready);

    // R4: after picking B the A input owes a drop.
    a_r4_owe_a: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && sel_data |=> a_ready);

    // R8: nothing from the select queue is consumed while the output is full.
    a_r8_no_consume_full: assert property (@(posedge clk) disable iff (!rst_n)
        !out_ready |-> !sel_ready);

    // R8: a stalled output token is offered again unchanged.
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready && $stable(sel_data) |=> $past(out_valid) &&
        ($stable(a_data) && $stable(b_data) ? $stable(out_data) : 1'b1));

endmodule

bind li_drop_mux li_drop_mux_checker #(.DATA_W(DATA_W)) i_checker (.*);

// File: tb/test_li_drop_mux.sv
// Bench for li_drop_mux: a vector table walked cycle by cycle, then
// directed checks for reset and the idle corner.
module test_li_drop_mux;

    localparam int unsigned DATA_W   = 8;
    localparam int unsigned DROP_MAX = 2;
    localparam time         CLK_P    = 10ns;
    localparam int          NV       = 15;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              sel_valid, sel_data, sel_ready;
    logic              a_valid, a_ready, b_valid, b_ready;
    logic [DATA_W-1:0] a_data, b_data, out_data;
    logic              out_valid, out_ready;

    int n_run  = 0;
    int n_fail = 0;

    always #(CLK_P/2) clk = ~clk;

    li_drop_mux #(.DATA_W(DATA_W), .DROP_MAX(DROP_MAX)) i_li_drop_mux (.*);

    // Stimulus {sv,s,av,ad,bv,bd,or} and expected {ov,od,sr,ar,br}.
    typedef struct packed {
        logic       sv; logic s; logic av; logic [7:0] ad;
        logic       bv; logic [7:0] bd; logic orr;
        logic       ov; logic [7:0] od; logic sr; logic ar; logic br;
    } vec_t;

    localparam vec_t VT [NV] = '{
        '{1,0,1,8'h11,0,8'h00,1, 1,8'h11,1,1,0}, // R2 B absent, A used, B owes 1
        '{0,0,0,8'h00,1,8'h22,1, 0,8'h00,0,0,1}, // R4 B token dropped
        '{1,1,0,8'h00,1,8'h33,0, 1,8'h33,0,0,0}, // R8 output full, hold
        '{1,1,0,8'h00,1,8'h33,1, 1,8'h33,1,0,1}, // R3 B used, A owes 1
        '{1,0,0,8'h00,0,8'h00,1, 0,8'h00,0,1,0}, // R5 A owing, ready high
        '{1,0,1,8'h44,0,8'h00,1, 0,8'h00,0,1,0}, // R6 stale A dropped, no output
        '{1,0,1,8'h55,0,8'h00,1, 1,8'h55,1,1,0}, // R9 A used, B owes 1
        '{1,0,1,8'h66,0,8'h00,1, 1,8'h66,1,1,1}, // R9 A used, B owes 2
        '{1,0,1,8'h77,0,8'h00,1, 0,8'h00,0,0,1}, // R7 B at limit, select blocked
        '{1,0,1,8'h77,1,8'h88,1, 0,8'h00,0,0,1}, // R7 B drop frees space
        '{1,0,1,8'h77,1,8'h99,1, 1,8'h77,1,1,1}, // R5 drop and use same cycle
        '{0,0,0,8'h00,1,8'hAA,1, 0,8'h00,0,0,1}, // R5 last owed B drop
        '{1,1,0,8'h00,1,8'hBB,1, 1,8'hBB,1,0,1}, // R1 B used, A owes 1
        '{0,0,1,8'hCC,0,8'h00,1, 0,8'h00,0,1,0}, // R5 A dropped
        '{0,0,1,8'hDD,1,8'hEE,1, 0,8'h00,0,0,0}  // R5 counts zero, no ready
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        sel_valid = v.sv; sel_data = v.s;
        a_valid = v.av; a_data = v.ad;
        b_valid = v.bv; b_data = v.bd;
        out_ready = v.orr;
    endtask

    task automatic idle();
        sel_valid = 0; sel_data = 0; a_valid = 0; a_data = '0;
        b_valid = 0; b_data = '0; out_ready = 1;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(CLK_P * 5000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        idle();
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;

        // R10: after reset neither input owes drops.
        a_valid = 1; b_valid = 1; #1;
        check("R10", "a_ready", 32'(a_ready), 0);
        check("R10", "b_ready", 32'(b_ready), 0);
        check("R10", "out_valid", 32'(out_valid), 0);
        idle();

        // Table walk: inputs at negedge, sampled 1 ns later.
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VT[i]);
            #1;
            check("R1", $sformatf("v%0d out_valid", i), 32'(out_valid), 32'(VT[i].ov));
            if (VT[i].ov)
                check("R9", $sformatf("v%0d out_data", i), 32'(out_data), 32'(VT[i].od));
            check("R3", $sformatf("v%0d sel_ready", i), 32'(sel_ready), 32'(VT[i].sr));
            check("R5", $sformatf("v%0d a_ready", i), 32'(a_ready), 32'(VT[i].ar));
            check("R4", $sformatf("v%0d b_ready", i), 32'(b_ready), 32'(VT[i].br));
        end

        // R10: reset clears an owed drop.
        @(negedge clk);
        idle(); sel_valid = 1; a_valid = 1; a_data = 8'h5A;
        @(negedge clk);
        idle(); rst_n = 0;
        @(negedge clk);
        rst_n = 1; b_valid = 1; #1;
        check("R10", "b_ready after reset", 32'(b_ready), 0);

        // R2: a valid unchosen input does not change the output decision.
        @(negedge clk);
        idle(); sel_valid = 1; sel_data = 1; b_valid = 1; b_data = 8'h3C;
        a_valid = 0; out_ready = 0; #1;
        check("R2", "out_valid A absent", 32'(out_valid), 1);
        a_valid = 1; #1;
        check("R2", "out_valid A present", 32'(out_valid), 1);
        check("R8", "sel_ready stalled", 32'(sel_ready), 0);

        // R1: no select token means no output.
        sel_valid = 0; #1;
        check("R1", "out_valid no select", 32'(out_valid), 0);

        @(negedge clk);
        idle();
        @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule